// File: doc/BRIEF.md
# Uncore Event Counter Unit

This block counts hardware events for performance analysis. It holds a configurable number of wide counters (eight 64-bit counters by default). Each counter picks what it counts with an 8-bit event code. The choices are clock cycles and the write-data and read-data strobes of two traffic ports. Software reaches every register through a single-cycle register port. A write takes effect at the next clock edge, and read data is a combinational function of the address presented.

Counting requires three things at once: the global run bit is set, the counter's own enable bit is set, and the selected event fires. A counter that rolls over from all ones to zero latches a sticky overflow status bit. Any unmasked status bit raises the interrupt output one cycle later. Software clears status with a write-1 clear register and can reload any counter at any time. A constant version word and a configuration register holding a power-management override bit complete the map.

Top module: `evt_count_unit`

## Requirements
- R1: After reset every register reads zero except the interrupt mask at 0x1C70, which reads all ones. The interrupt output is low.
- R2: Counter n is a full-width register at byte address 0x1D00 + 8*n. Software can read it and write it.
- R3: Bit 0 of the register at 0x1C00 is the global run bit. While it is 0, no counter changes except by a software write.
- R4: Bit n of the register at 0x1C04 enables counter n. A cleared bit holds counter n.
- R5: Counter n takes its 8-bit event code from bits [8*(n%4)+7 : 8*(n%4)]. Counters 0–3 read the register at 0x1C80 and counters 4–7 read the one at 0x1C84.
- R6: Code 0x00 counts every cycle. Code 0xE1 counts port 0 write strobes, 0xE2 port 0 read strobes, 0x61 port 1 write strobes and 0x62 port 1 read strobes. Any other code never advances the counter.
- R7: When an enabled counter steps from all ones to zero, status bit n at 0x1C78 is set at that same edge. It stays set until cleared.
- R8: Writing 1 to bit n of 0x1C7C clears status bit n, and writing 0 leaves it unchanged. A rollover in the same cycle as its clear leaves the bit set.
- R9: Mask bit n at 0x1C70 blocks status bit n from the interrupt when 1 and passes it when 0.
- R10: The interrupt output equals the OR of status AND NOT mask, registered one cycle behind those registers.
- R11: A software write to a counter in a cycle where it would also advance loads the written value, with no increment and no rollover.
- R12: The word at 0x1CF0 returns the version parameter, and writes to it have no effect.
- R13: Only bit 9 of the register at 0x0534 is stored; its other bits and every unmapped address read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 16 | Byte address |
| reg_wdata | input | 64 | Write data; 32-bit registers use bits 31:0 |
| reg_rdata | output | 64 | Read data for reg_addr, zero-extended |
| evt_wr_strb | input | 2 | Write-data strobes, bit p for port p |
| evt_rd_strb | input | 2 | Read-data strobes, bit p for port p |
| irq | output | 1 | Registered interrupt request |

## Verification
The counting path is exercised first with a directed code set that puts every recognised code and two unrecognised ones on different counters under random port strobes. This separates correct code decoding from crossed ports and wrong byte lanes. Counters are then preloaded just below all ones under cycle counting, which reaches rollover, the sticky status bit, the mask and the one-cycle interrupt delay within a few cycles. A long random phase interleaves counter reloads (often near the wrap point), select, enable, mask and clear writes with random strobes. Its collisions of write with increment and of clear with rollover test the priority rules, which directed sequences seldom hit.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
   localparam logic [15:0] OFS_CFG      = 16'h0534;
   localparam logic [15:0] OFS_CTRL     = 16'h1C00;
   localparam logic [15:0] OFS_CNT_EN   = 16'h1C04;
   localparam logic [15:0] OFS_IRQ_MASK = 16'h1C70;
   localparam logic [15:0] OFS_IRQ_STAT = 16'h1C78;
   localparam logic [15:0] OFS_IRQ_CLR  = 16'h1C7C;
   localparam logic [15:0] OFS_SEL_BASE = 16'h1C80;
   localparam logic [15:0] OFS_VERSION  = 16'h1CF0;
   localparam logic [15:0] OFS_CNT_BASE = 16'h1D00;

   localparam int CNT_STRIDE    = 8;
   localparam int SEL_STRIDE    = 4;
   localparam int CODES_PER_SEL = 4;
   localparam int CODE_W        = 8;
   localparam int CFG_PM_BIT    = 9;
   localparam int NUM_PORT      = 2;

   localparam logic [CODE_W-1:0] EV_CYCLES = 8'h00;
   localparam logic [CODE_W-1:0] EV_P1_WR  = 8'h61;
   localparam logic [CODE_W-1:0] EV_P1_RD  = 8'h62;
   localparam logic [CODE_W-1:0] EV_P0_WR  = 8'hE1;
   localparam logic [CODE_W-1:0] EV_P0_RD  = 8'hE2;
endpackage

// File: rtl/ecu_evt_match.sv
module ecu_evt_match
   import ecu_pkg::*;
(
   input  logic [CODE_W-1:0]   code,
   input  logic [NUM_PORT-1:0] wr_strb,
   input  logic [NUM_PORT-1:0] rd_strb,
   output logic                hit
);
   always_comb begin
      case (code)
         EV_CYCLES: hit = 1'b1;
         EV_P0_WR:  hit = wr_strb[0];
         EV_P0_RD:  hit = rd_strb[0];
         EV_P1_WR:  hit = wr_strb[1];
         EV_P1_RD:  hit = rd_strb[1];
         default:   hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/ecu_counter.sv
module ecu_counter #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             glob_en,
   input  logic             cnt_en,
   input  logic             evt_hit,
   input  logic             sw_wr,
   input  logic [CNT_W-1:0] sw_data,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wrap
);
   logic step;

   assign step = glob_en & cnt_en & evt_hit & ~sw_wr;
   assign wrap = step & (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (sw_wr)  cnt_q <= sw_data;
      else if (step)   cnt_q <= cnt_q + 1'b1;
   end

   a_r3_global_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!glob_en && !sw_wr) |=> $stable(cnt_q));
   a_r4_local_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !sw_wr) |=> $stable(cnt_q));
   a_r6_no_event_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_hit && !sw_wr) |=> $stable(cnt_q));
   a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr |=> (cnt_q == $past(sw_data)));
   a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt_q == '0));
endmodule

// File: rtl/ecu_irq_ctrl.sv
module ecu_irq_ctrl #(
   parameter int NUM_CNT = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CNT-1:0] wrap,
   input  logic               clr_wr,
   input  logic [NUM_CNT-1:0] clr_bits,
   input  logic [NUM_CNT-1:0] mask,
   output logic [NUM_CNT-1:0] status_q,
   output logic               irq
);
   logic [NUM_CNT-1:0] clr_eff;

   assign clr_eff = clr_wr ? clr_bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         irq      <= 1'b0;
      end else begin
         status_q <= wrap | (status_q & ~clr_eff);
         irq      <= |(status_q & ~mask);
      end
   end

   a_r7_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap != '0) |=> ((status_q & $past(wrap)) == $past(wrap)));
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> ((status_q & $past(status_q)) == $past(status_q)));
   a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(status_q) != '0));
   a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q & ~mask) == '0) |=> !irq);
endmodule

// File: rtl/evt_count_unit.sv
module evt_count_unit
   import ecu_pkg::*;
#(
   parameter int          NUM_CNT = 8,
   parameter int          CNT_W   = 64,
   parameter int          ADDR_W  = 16,
   parameter logic [31:0] VERSION = 32'h0000_0130
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [63:0]         reg_wdata,
   output logic [63:0]         reg_rdata,
   input  logic [NUM_PORT-1:0] evt_wr_strb,
   input  logic [NUM_PORT-1:0] evt_rd_strb,
   output logic                irq
);
   localparam int NUM_SEL = NUM_CNT / CODES_PER_SEL;

   if (NUM_CNT % CODES_PER_SEL != 0 || NUM_CNT < CODES_PER_SEL || NUM_CNT > 32) begin : g_bad_num_cnt
      $error("NUM_CNT must be a multiple of 4 between 4 and 32");
   end
   if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cnt_w
      $error("CNT_W must lie between 2 and 64");
   end
   if (ADDR_W < 16) begin : g_bad_addr_w
      $error("ADDR_W must be at least 16");
   end

   logic                 run_q;
   logic [NUM_CNT-1:0]   en_q;
   logic [NUM_CNT-1:0]   mask_q;
   logic                 pm_ovr_q;
   logic [31:0]          sel_q [NUM_SEL];
   logic [CNT_W-1:0]     cnt_q [NUM_CNT];
   logic [NUM_CNT-1:0]   cnt_wr;
   logic [NUM_CNT-1:0]   hit;
   logic [NUM_CNT-1:0]   wrap;
   logic [NUM_CNT-1:0]   status;
   logic                 clr_wr;

   function automatic logic at(input logic [ADDR_W-1:0] a, input int ofs);
      return a == ADDR_W'(ofs);
   endfunction

   assign clr_wr = reg_wr && at(reg_addr, int'(OFS_IRQ_CLR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         en_q     <= '0;
         mask_q   <= '1;
         pm_ovr_q <= 1'b0;
         for (int s = 0; s < NUM_SEL; s++) sel_q[s] <= '0;
      end else if (reg_wr) begin
         if (at(reg_addr, int'(OFS_CTRL)))     run_q    <= reg_wdata[0];
         if (at(reg_addr, int'(OFS_CNT_EN)))   en_q     <= reg_wdata[NUM_CNT-1:0];
         if (at(reg_addr, int'(OFS_IRQ_MASK))) mask_q   <= reg_wdata[NUM_CNT-1:0];
         if (at(reg_addr, int'(OFS_CFG)))      pm_ovr_q <= reg_wdata[CFG_PM_BIT];
         for (int s = 0; s < NUM_SEL; s++) begin
            if (at(reg_addr, int'(OFS_SEL_BASE) + SEL_STRIDE * s)) sel_q[s] <= reg_wdata[31:0];
         end
      end
   end

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      localparam int SEL_IDX = i / CODES_PER_SEL;
      localparam int LANE    = CODE_W * (i % CODES_PER_SEL);

      assign cnt_wr[i] = reg_wr && at(reg_addr, int'(OFS_CNT_BASE) + CNT_STRIDE * i);

      ecu_evt_match u_match (
         .code    (sel_q[SEL_IDX][LANE +: CODE_W]),
         .wr_strb (evt_wr_strb),
         .rd_strb (evt_rd_strb),
         .hit     (hit[i])
      );

      ecu_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .glob_en (run_q),
         .cnt_en  (en_q[i]),
         .evt_hit (hit[i]),
         .sw_wr   (cnt_wr[i]),
         .sw_data (reg_wdata[CNT_W-1:0]),
         .cnt_q   (cnt_q[i]),
         .wrap    (wrap[i])
      );
   end

   ecu_irq_ctrl #(.NUM_CNT(NUM_CNT)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wrap     (wrap),
      .clr_wr   (clr_wr),
      .clr_bits (reg_wdata[NUM_CNT-1:0]),
      .mask     (mask_q),
      .status_q (status),
      .irq      (irq)
   );

   always_comb begin
      reg_rdata = '0;
      if (at(reg_addr, int'(OFS_CTRL)))     reg_rdata[0] = run_q;
      if (at(reg_addr, int'(OFS_CNT_EN)))   reg_rdata[NUM_CNT-1:0] = en_q;
      if (at(reg_addr, int'(OFS_IRQ_MASK))) reg_rdata[NUM_CNT-1:0] = mask_q;
      if (at(reg_addr, int'(OFS_IRQ_STAT))) reg_rdata[NUM_CNT-1:0] = status;
      if (at(reg_addr, int'(OFS_VERSION)))  reg_rdata[31:0] = VERSION;
      if (at(reg_addr, int'(OFS_CFG)))      reg_rdata[CFG_PM_BIT] = pm_ovr_q;
      for (int s = 0; s < NUM_SEL; s++) begin
         if (at(reg_addr, int'(OFS_SEL_BASE) + SEL_STRIDE * s)) reg_rdata[31:0] = sel_q[s];
      end
      for (int c = 0; c < NUM_CNT; c++) begin
         if (at(reg_addr, int'(OFS_CNT_BASE) + CNT_STRIDE * c)) reg_rdata = 64'(cnt_q[c]);
      end
   end

   a_r8_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && (wrap == '0)) |=> ((status & $past(reg_wdata[NUM_CNT-1:0])) == '0));
endmodule

// File: tb/evt_count_unit_tb.sv
`timescale 1ns/1ps
module evt_count_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic [1:0]  evt_wr_strb = '0;
   logic [1:0]  evt_rd_strb = '0;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   evt_count_unit u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .evt_wr_strb(evt_wr_strb), .evt_rd_strb(evt_rd_strb), .irq(irq)
   );

   localparam logic [31:0] VER = 32'h0000_0130;

   logic [63:0] m_cnt [8];
   logic [31:0] m_sel [2];
   logic [7:0]  m_en, m_mask, m_stat;
   logic        m_run, m_pm, m_irq;

   function automatic logic ev_hit(input logic [7:0] c, input logic [1:0] ws, input logic [1:0] rs);
      case (c)
         8'h00: return 1'b1;
         8'hE1: return ws[0];
         8'hE2: return rs[0];
         8'h61: return ws[1];
         8'h62: return rs[1];
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [63:0] exp_read(input logic [15:0] a);
      for (int n = 0; n < 8; n++) if (a == 16'h1D00 + 16'(8 * n)) return m_cnt[n];
      case (a)
         16'h1C00: return {63'd0, m_run};
         16'h1C04: return {56'd0, m_en};
         16'h1C70: return {56'd0, m_mask};
         16'h1C78: return {56'd0, m_stat};
         16'h1C80: return {32'd0, m_sel[0]};
         16'h1C84: return {32'd0, m_sel[1]};
         16'h1CF0: return {32'd0, VER};
         16'h0534: return {54'd0, m_pm, 9'd0};
         default:  return 64'd0;
      endcase
   endfunction

   function automatic string tag_of(input logic [15:0] a);
      if (a >= 16'h1D00 && a < 16'h1D40) return "R2";
      case (a)
         16'h1C00: return "R3";
         16'h1C04: return "R4";
         16'h1C70: return "R9";
         16'h1C78: return "R7";
         16'h1C80, 16'h1C84: return "R5";
         16'h1CF0: return "R12";
         default:  return "R13";
      endcase
   endfunction

   // Reference model, updated from the requirements at every rising edge.
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int n = 0; n < 8; n++) m_cnt[n] = '0;
         m_sel[0] = '0; m_sel[1] = '0;
         m_en = '0; m_mask = 8'hFF; m_stat = '0;
         m_run = 1'b0; m_pm = 1'b0; m_irq = 1'b0;
      end else begin
         logic [7:0] wrapv;
         logic [7:0] clr;
         wrapv = '0;
         for (int n = 0; n < 8; n++) begin
            logic [7:0] code;
            code = m_sel[n / 4][8 * (n % 4) +: 8];
            if (reg_wr && reg_addr == 16'h1D00 + 16'(8 * n)) begin
               m_cnt[n] = reg_wdata;
            end else if (m_run && m_en[n] && ev_hit(code, evt_wr_strb, evt_rd_strb)) begin
               if (m_cnt[n] == '1) wrapv[n] = 1'b1;
               m_cnt[n] = m_cnt[n] + 64'd1;
            end
         end
         m_irq = |(m_stat & ~m_mask);
         clr = (reg_wr && reg_addr == 16'h1C7C) ? reg_wdata[7:0] : 8'd0;
         m_stat = wrapv | (m_stat & ~clr);
         if (reg_wr) begin
            case (reg_addr)
               16'h1C00: m_run = reg_wdata[0];
               16'h1C04: m_en = reg_wdata[7:0];
               16'h1C70: m_mask = reg_wdata[7:0];
               16'h1C80: m_sel[0] = reg_wdata[31:0];
               16'h1C84: m_sel[1] = reg_wdata[31:0];
               16'h0534: m_pm = reg_wdata[9];
               default: ;
            endcase
         end
      end
   end

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic step(input logic wr, input logic [15:0] a, input logic [63:0] d,
                       input logic [1:0] ws, input logic [1:0] rs, input string tag);
      reg_wr = wr; reg_addr = a; reg_wdata = d;
      evt_wr_strb = ws; evt_rd_strb = rs;
      @(posedge clk);
      @(negedge clk);
      check("R10", {63'd0, irq}, {63'd0, m_irq});
      check(tag == "" ? tag_of(a) : tag, reg_rdata, exp_read(a));
   endtask

   task automatic wr(input logic [15:0] a, input logic [63:0] d, input string tag);
      step(1'b1, a, d, 2'b00, 2'b00, tag);
   endtask

   task automatic rd(input logic [15:0] a, input string tag);
      step(1'b0, a, 64'd0, 2'b00, 2'b00, tag);
   endtask

   task automatic run_rand(input int n, input logic [15:0] a, input string tag);
      for (int k = 0; k < n; k++) step(1'b0, a, 64'd0, 2'($urandom), 2'($urandom), tag);
   endtask

   function automatic logic [7:0] pick_code();
      case ($urandom % 7)
         0: return 8'h00;
         1: return 8'h61;
         2: return 8'h62;
         3: return 8'hE1;
         4: return 8'hE2;
         default: return 8'($urandom);
      endcase
   endfunction

   function automatic logic [15:0] pick_addr();
      int r;
      r = $urandom % 20;
      if (r < 8) return 16'h1D00 + 16'(8 * r);
      case (r)
         8: return 16'h1C80;
         9: return 16'h1C84;
         10: return 16'h1C00;
         11: return 16'h1C04;
         12: return 16'h1C70;
         13, 14, 15: return 16'h1C78;
         16: return 16'h1CF0;
         17: return 16'h0534;
         18: return 16'h1C7C;
         default: return 16'h1C08;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      foreach (m_cnt[n]) rd(16'h1D00 + 16'(8 * n), "R1");
      rd(16'h1C00, "R1"); rd(16'h1C04, "R1"); rd(16'h1C70, "R1");
      rd(16'h1C78, "R1"); rd(16'h1C80, "R1"); rd(16'h1C84, "R1");
      rd(16'h0534, "R1");
      check("R1", {63'd0, irq}, 64'd0);

      // R12: version constant, write ignored
      rd(16'h1CF0, "R12");
      wr(16'h1CF0, 64'h0000_0000_DEAD_BEEF, "R12");
      rd(16'h1CF0, "R12");

      // R13: only bit 9 of the configuration register sticks; holes read zero
      wr(16'h0534, 64'hFFFF_FFFF_FFFF_FFFF, "R13");
      rd(16'h0534, "R13");
      rd(16'h1C08, "R13");

      // R2: counter write/read
      foreach (m_cnt[n]) wr(16'h1D00 + 16'(8 * n), {32'hA5A5_0000 + 32'(n), 32'h1234_5678 ^ 32'(n)}, "R2");
      foreach (m_cnt[n]) rd(16'h1D00 + 16'(8 * n), "R2");

      // R5/R6: lanes and codes, two unrecognised codes on counters 5 and 6
      foreach (m_cnt[n]) wr(16'h1D00 + 16'(8 * n), 64'd0, "R2");
      wr(16'h1C80, 64'h0000_0000_E162_6100, "R5");
      wr(16'h1C84, 64'h0000_0000_00FF_33E2, "R5");
      wr(16'h1C04, 64'hFF, "R4");
      wr(16'h1C00, 64'h1, "R3");
      run_rand(24, 16'h1C78, "R6");
      foreach (m_cnt[n]) rd(16'h1D00 + 16'(8 * n), (n == 5 || n == 6) ? "R6" : "R5");

      // R3: global stop freezes counters despite strobes
      wr(16'h1C00, 64'h0, "R3");
      run_rand(8, 16'h1D00, "R3");
      foreach (m_cnt[n]) rd(16'h1D00 + 16'(8 * n), "R3");

      // R4: local enable cleared on counter 2
      wr(16'h1C04, 64'hFB, "R4");
      wr(16'h1C00, 64'h1, "R3");
      run_rand(10, 16'h1D10, "R4");
      rd(16'h1D10, "R4");

      // R7/R9/R10: wrap on counter 0 (cycle code), mask toggling
      wr(16'h1D00, 64'hFFFF_FFFF_FFFF_FFFC, "R7");
      rd(16'h1C78, "R7");
      rd(16'h1C78, "R7");
      rd(16'h1C78, "R7");
      rd(16'h1C78, "R7");
      wr(16'h1C70, 64'hFE, "R9");
      rd(16'h1C78, "R10");
      rd(16'h1C78, "R10");
      wr(16'h1C70, 64'hFF, "R9");
      rd(16'h1C78, "R9");

      // R8: clear with zero has no effect, clear with one removes the bit
      wr(16'h1C7C, 64'h00, "R8");
      rd(16'h1C78, "R8");
      wr(16'h1C7C, 64'h01, "R8");
      rd(16'h1C78, "R8");

      // R8: clear in the same cycle as a rollover keeps the bit
      wr(16'h1D00, 64'hFFFF_FFFF_FFFF_FFFF, "R11");
      wr(16'h1C7C, 64'h01, "R8");
      rd(16'h1C78, "R8");

      // R11: write while counting loads the written value, no increment
      wr(16'h1D00, 64'h0000_0000_0000_1000, "R11");
      wr(16'h1D00, 64'hFFFF_FFFF_FFFF_FFFF, "R11");
      rd(16'h1D00, "R11");
      rd(16'h1C78, "R11");

      // Random phase
      wr(16'h1C7C, 64'hFF, "R8");
      wr(16'h1C04, 64'hFF, "R4");
      for (int k = 0; k < 3000; k++) begin
         int op;
         logic [1:0] ws, rs;
         ws = 2'($urandom); rs = 2'($urandom);
         op = $urandom % 16;
         case (op)
            0, 1, 2: begin
               int idx;
               logic [63:0] v;
               idx = $urandom % 8;
               v = ($urandom % 2 == 0) ? (64'hFFFF_FFFF_FFFF_FFF0 | 64'($urandom % 16))
                                      : {32'($urandom), 32'($urandom)};
               step(1'b1, 16'h1D00 + 16'(8 * idx), v, ws, rs, "R11");
            end
            3: step(1'b1, ($urandom % 2 == 0) ? 16'h1C80 : 16'h1C84,
                    {32'd0, pick_code(), pick_code(), pick_code(), pick_code()}, ws, rs, "R5");
            4: step(1'b1, 16'h1C04, 64'($urandom % 256), ws, rs, "R4");
            5: step(1'b1, 16'h1C70, 64'($urandom % 256), ws, rs, "R9");
            6: step(1'b1, 16'h1C7C, 64'($urandom % 256), ws, rs, "R8");
            7: step(1'b1, 16'h1C00, 64'(($urandom % 5) != 0), ws, rs, "R3");
            8: step(1'b1, 16'h0534, {32'($urandom), 32'($urandom)}, ws, rs, "R13");
            default: step(1'b0, pick_addr(), 64'd0, ws, rs, "");
         endcase
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule